// File: doc/BRIEF.md
# LPC Memory-Cycle Target

This block sits on a 4-bit Low Pin Count bus as a clocked target for memory read and memory write cycles. It samples the active-low frame strobe and the four multiplexed address/data lines on each rising clock edge. It decodes the cycle type and a 32-bit address, and it accepts the cycle only when three device-select address bits match the block's strap inputs. An accepted cycle is handed to a simple downstream port as a single-cycle read or write strobe. The block then answers the host with sync nibbles. A read cycle also returns the data byte as two nibbles.

The downstream side carries an address, write data, a read strobe and a write strobe. The target holds the bus in the "wait" sync code until the downstream side raises its ready flag. For a read, ready also qualifies the read data. The host may cancel a cycle at any point by pulling the frame strobe low. The block then leaves the bus on the next edge. A request that has already gone downstream is not withdrawn. The block has two active-low reset pins, and either one returns it to idle.

Top module: `lpc_mem_target`

## Requirements
- R1: While either reset pin is low at a rising edge, the block goes idle: lad_oe is 0 after that edge, and neither mem_rd nor mem_wr is asserted.
- R2: A cycle starts only when frame_n is sampled low together with the start nibble 4'b0000. A low frame_n with any other nibble starts nothing.
- R3: The nibble after the start selects the cycle type: 4'b010x is a memory read and 4'b011x is a memory write. Any other type is ignored and the lines are never driven.
- R4: The address follows as 8 nibbles, most significant nibble first. mem_addr carries the low ADDR_W bits of that address.
- R5: The cycle is accepted only when address bits 21:19 equal the bit-wise inverse of strap_id (all-zero straps answer to 3'b111). Otherwise lad_oe stays 0 and no strobe is issued.
- R6: lad_oe stays 0 during the two host turnaround clocks. After its last nibble the target drives 4'b1111 for one clock and then releases the lines.
- R7: After turnaround the target drives sync 4'b0101 while the downstream request is outstanding. It drives 4'b0000 once ready has been seen. A response with latency L clocks after the strobe gives max(L-1,0) wait nibbles.
- R8: On a read, the clock after the ready sync carries read data bits 3:0 and the following clock carries bits 7:4.
- R9: On a write, the host sends data bits 3:0 and then bits 7:4. A single mem_wr strobe then carries that byte on mem_wdata and the address on mem_addr.
- R10: mem_rd and mem_wr are never high together and last exactly one clock. An accepted cycle produces exactly one strobe.
- R11: If frame_n is sampled low during a cycle, lad_oe is 0 after that edge and the cycle ends. If the nibble was 4'b0000, a new cycle begins.
- R12: An abort that arrives after a write's data has been received does not cancel the write strobe already issued, and the bus is still released.
- R13: With frame_n high and no cycle in progress, lad_oe stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, all sampling on the rising edge |
| iface_rst_n | input | 1 | Active-low interface reset |
| cpu_rst_n | input | 1 | Active-low processor reset, combined with iface_rst_n by AND |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Nibble sampled from the shared address/data lines |
| lad_out | output | 4 | Nibble the target drives onto the lines |
| lad_oe | output | 1 | Output enable for lad_out; 0 means high impedance |
| strap_id | input | 3 | Device-select straps, compared inverted with address bits 21:19 |
| mem_addr | output | ADDR_W | Downstream address |
| mem_wdata | output | 8 | Downstream write byte |
| mem_wr | output | 1 | One-clock downstream write strobe |
| mem_rd | output | 1 | One-clock downstream read strobe |
| mem_rdata | input | 8 | Downstream read byte, valid with mem_ready |
| mem_ready | input | 1 | Downstream completion flag for the outstanding request |

## Verification
The assertions assume several things about the block's neighbours. The downstream side answers each strobe with exactly one ready pulse. No stale ready from an aborted request arrives after a new request has been issued. strap_id is held steady while a cycle is open. The stimulus changes inputs only on falling edges. After an abort that leaves a slow request outstanding, it lets the responder's late pulse drain before the next cycle is issued. When it restarts a cycle directly from an abort, it chooses a latency short enough that the old ready falls before the new strobe.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CTYPE, ST_ADDR, ST_WLO, ST_WHI,
    ST_HTAR1, ST_HTAR2, ST_SYNC, ST_RLO, ST_RHI, ST_TTAR
  } lpc_state_e;

  localparam logic [3:0] NIB_START     = 4'b0000;
  localparam logic [3:0] NIB_SYNC_WAIT = 4'b0101;
  localparam logic [3:0] NIB_SYNC_OK   = 4'b0000;
  localparam logic [3:0] NIB_TAR       = 4'b1111;
  localparam logic [2:0] TYPE_MEM_RD   = 3'b010;
  localparam logic [2:0] TYPE_MEM_WR   = 3'b011;
  localparam int         ADDR_NIBS     = 8;

endpackage

// File: rtl/lpc_frame_fsm.sv
module lpc_frame_fsm
  import lpc_tgt_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int SEL_LSB = 19,
  parameter int SEL_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic [3:0]        lad_in,
  input  logic [SEL_W-1:0]  strap_id,
  input  logic              done,
  output lpc_state_e        state_o,
  output logic              is_write,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o,
  output logic              issue
);

  localparam int KEEP_W = SEL_LSB + SEL_W;
  localparam int CNT_W  = $clog2(ADDR_NIBS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_NIBS - 1);

  lpc_state_e        state_q;
  logic              wr_q;
  logic [KEEP_W-5:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;
  logic              issue_q;
  logic [KEEP_W-1:0] full_addr;
  logic              sel_hit;

  // Only the bits up to the device-select field are kept; higher nibbles drop off.
  always_comb begin
    full_addr = {shift_q, lad_in};
    sel_hit   = (full_addr[SEL_LSB +: SEL_W] == ~strap_id);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      shift_q <= '0;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      issue_q <= 1'b0;
    end else begin
      issue_q <= 1'b0;
      if (!frame_n) begin
        // Frame low: abort anything in flight; a start nibble opens a new cycle.
        state_q <= (lad_in == NIB_START) ? ST_CTYPE : ST_IDLE;
      end else begin
        case (state_q)
          ST_CTYPE: begin
            cnt_q <= '0;
            if (lad_in[3:1] == TYPE_MEM_RD) begin
              wr_q    <= 1'b0;
              state_q <= ST_ADDR;
            end else if (lad_in[3:1] == TYPE_MEM_WR) begin
              wr_q    <= 1'b1;
              state_q <= ST_ADDR;
            end else begin
              state_q <= ST_IDLE;
            end
          end
          ST_ADDR: begin
            shift_q <= full_addr[KEEP_W-5:0];
            cnt_q   <= cnt_q + CNT_W'(1);
            if (cnt_q == CNT_LAST) begin
              if (!sel_hit) begin
                state_q <= ST_IDLE;
              end else begin
                addr_q <= full_addr[ADDR_W-1:0];
                if (wr_q) begin
                  state_q <= ST_WLO;
                end else begin
                  state_q <= ST_HTAR1;
                  issue_q <= 1'b1;
                end
              end
            end
          end
          ST_WLO: begin
            wdata_q[3:0] <= lad_in;
            state_q      <= ST_WHI;
          end
          ST_WHI: begin
            wdata_q[7:4] <= lad_in;
            state_q      <= ST_HTAR1;
            issue_q      <= 1'b1;
          end
          ST_HTAR1: state_q <= ST_HTAR2;
          ST_HTAR2: state_q <= ST_SYNC;
          ST_SYNC: begin
            if (done) state_q <= wr_q ? ST_TTAR : ST_RLO;
          end
          ST_RLO:  state_q <= ST_RHI;
          ST_RHI:  state_q <= ST_TTAR;
          ST_TTAR: state_q <= ST_IDLE;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign state_o  = state_q;
  assign is_write = wr_q;
  assign addr_o   = addr_q;
  assign wdata_o  = wdata_q;
  assign issue    = issue_q;

endmodule

// File: rtl/lpc_mem_port.sv
module lpc_mem_port (
  input  logic       clk,
  input  logic       rst,
  input  logic       issue,
  input  logic       is_write,
  input  logic       cyc_clear,
  input  logic       mem_ready,
  input  logic [7:0] mem_rdata,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       done,
  output logic [7:0] rdata
);

  logic       pend_q;
  logic       done_q;
  logic [7:0] rdata_q;
  logic       take;

  assign mem_rd = issue & ~is_write;
  assign mem_wr = issue & is_write;

  // A response is taken for the current request only, once.
  assign take = !cyc_clear && !done_q && (issue || pend_q) && mem_ready;

  always_ff @(posedge clk) begin
    if (rst || cyc_clear) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else if (take) begin
      pend_q <= 1'b0;
      done_q <= 1'b1;
    end else if (issue) begin
      pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (take && !is_write) rdata_q <= mem_rdata;
  end

  assign done  = done_q;
  assign rdata = rdata_q;

endmodule

// File: rtl/lpc_lad_driver.sv
module lpc_lad_driver
  import lpc_tgt_pkg::*;
(
  input  lpc_state_e state,
  input  logic       done,
  input  logic [7:0] rdata,
  output logic [3:0] lad_out,
  output logic       lad_oe
);

  // Decoded from registers only, so the pins change right after the clock edge.
  always_comb begin
    lad_oe  = 1'b1;
    lad_out = NIB_TAR;
    case (state)
      ST_SYNC: lad_out = done ? NIB_SYNC_OK : NIB_SYNC_WAIT;
      ST_RLO:  lad_out = rdata[3:0];
      ST_RHI:  lad_out = rdata[7:4];
      ST_TTAR: lad_out = NIB_TAR;
      default: lad_oe  = 1'b0;
    endcase
  end

endmodule

// File: rtl/lpc_mem_target.sv
module lpc_mem_target
  import lpc_tgt_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int SEL_LSB = 19,
  parameter int SEL_W   = 3
) (
  input  logic              clk,
  input  logic              iface_rst_n,
  input  logic              cpu_rst_n,
  input  logic              frame_n,
  input  logic [3:0]        lad_in,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  input  logic [SEL_W-1:0]  strap_id,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_wr,
  output logic              mem_rd,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ready
);

  logic       rst;
  lpc_state_e state;
  logic       is_write;
  logic       issue;
  logic       done;
  logic [7:0] rdata;
  logic       cyc_clear;

  assign rst       = ~(iface_rst_n & cpu_rst_n);
  assign cyc_clear = (state == ST_IDLE) || (state == ST_CTYPE);

  lpc_frame_fsm #(
    .ADDR_W (ADDR_W),
    .SEL_LSB(SEL_LSB),
    .SEL_W  (SEL_W)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .frame_n (frame_n),
    .lad_in  (lad_in),
    .strap_id(strap_id),
    .done    (done),
    .state_o (state),
    .is_write(is_write),
    .addr_o  (mem_addr),
    .wdata_o (mem_wdata),
    .issue   (issue)
  );

  lpc_mem_port u_port (
    .clk      (clk),
    .rst      (rst),
    .issue    (issue),
    .is_write (is_write),
    .cyc_clear(cyc_clear),
    .mem_ready(mem_ready),
    .mem_rdata(mem_rdata),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .done     (done),
    .rdata    (rdata)
  );

  lpc_lad_driver u_drv (
    .state  (state),
    .done   (done),
    .rdata  (rdata),
    .lad_out(lad_out),
    .lad_oe (lad_oe)
  );

endmodule

// File: rtl/lpc_mem_target_chk.sv
module lpc_mem_target_chk (
  input logic       clk,
  input logic       iface_rst_n,
  input logic       cpu_rst_n,
  input logic       frame_n,
  input logic [3:0] lad_out,
  input logic       lad_oe,
  input logic       mem_wr,
  input logic       mem_rd
);

  logic rst;
  assign rst = ~(iface_rst_n & cpu_rst_n);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!lad_oe && !mem_rd && !mem_wr));

  p_abort_release_r11: assert property (@(posedge clk) disable iff (rst)
    !frame_n |=> !lad_oe);

  p_strobe_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |=> !(mem_rd || mem_wr));

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  p_first_drive_sync_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(lad_oe) |-> (lad_out == 4'b0101 || lad_out == 4'b0000));

  p_wait_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (lad_oe && lad_out == 4'b0101 && frame_n) |=> lad_oe);

  p_strobe_no_drive_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> !lad_oe);

endmodule

bind lpc_mem_target lpc_mem_target_chk u_chk (
  .clk        (clk),
  .iface_rst_n(iface_rst_n),
  .cpu_rst_n  (cpu_rst_n),
  .frame_n    (frame_n),
  .lad_out    (lad_out),
  .lad_oe     (lad_oe),
  .mem_wr     (mem_wr),
  .mem_rd     (mem_rd)
);

// File: tb/lpc_mem_target_test.sv
`timescale 1ns/100ps
module lpc_mem_target_test;

  typedef struct packed {
    logic        wr;
    logic [18:0] addr;
    logic [7:0]  data;
  } req_t;

  logic        clk = 1'b0;
  logic        iface_rst_n = 1'b0;
  logic        cpu_rst_n = 1'b1;
  logic        frame_n = 1'b1;
  logic [3:0]  lad_in = 4'hF;
  logic [3:0]  lad_out;
  logic        lad_oe;
  logic [2:0]  strap_id = 3'b000;
  logic [18:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_wr, mem_rd;
  logic [7:0]  mem_rdata = 8'h00;
  logic        mem_ready = 1'b0;

  int   n_chk = 0;
  int   n_bad = 0;
  int   resp_lat = 0;
  bit   finished = 0;
  req_t exp_q[$];
  logic [7:0] model [256];

  lpc_mem_target uut (
    .clk(clk), .iface_rst_n(iface_rst_n), .cpu_rst_n(cpu_rst_n),
    .frame_n(frame_n), .lad_in(lad_in), .lad_out(lad_out), .lad_oe(lad_oe),
    .strap_id(strap_id), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Drive on the falling edge, then look just after the next rising edge.
  task automatic step(input logic fr_n, input logic [3:0] v);
    @(negedge clk);
    frame_n = fr_n;
    lad_in  = v;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    bit quiet = 1;
    for (int i = 0; i < n; i++) begin
      step(1'b1, 4'hF);
      if (lad_oe) quiet = 0;
    end
    chk(quiet, "R13", "idle lines released", 0, 0);
  endtask

  function automatic bit hits(input logic [31:0] a);
    return a[21:19] == ~strap_id;
  endfunction

  task automatic push(input logic wr, input logic [31:0] a, input logic [7:0] d);
    req_t it;
    it.wr = wr; it.addr = a[18:0]; it.data = d;
    exp_q.push_back(it);
  endtask

  task automatic send_head(input logic [3:0] typ, input logic [31:0] a);
    step(1'b0, 4'h0);
    chk(!lad_oe, "R11", "lines off at start", lad_oe, 0);
    step(1'b1, typ);
    for (int i = 7; i >= 0; i--) step(1'b1, a[i*4 +: 4]);
  endtask

  task automatic sync_phase(input int lat);
    int waits = 0;
    chk(!lad_oe, "R6", "host tar clock 1", lad_oe, 0);
    step(1'b1, 4'hF);
    chk(!lad_oe, "R6", "host tar clock 2", lad_oe, 0);
    step(1'b1, 4'hF);
    chk(lad_oe && (lad_out == 4'h5 || lad_out == 4'h0), "R7", "sync after tar", lad_out, 5);
    while (lad_oe && lad_out == 4'h5 && waits < 200) begin
      step(1'b1, 4'hF);
      waits++;
    end
    chk(waits == ((lat > 1) ? lat - 1 : 0), "R7", "wait sync count", waits, (lat > 1) ? lat - 1 : 0);
    chk(lad_oe && lad_out == 4'h0, "R7", "ready sync", lad_out, 0);
  endtask

  task automatic finish_quiet(input string tag);
    bit quiet = 1;
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 4'hF);
      if (lad_oe) quiet = 0;
    end
    chk(quiet, tag, "ignored cycle never drives", 0, 0);
  endtask

  task automatic do_read(input logic [31:0] a, input int lat);
    logic [7:0] e;
    bit h = hits(a);
    resp_lat = lat;
    e = model[a[7:0]];
    if (h) push(1'b0, a, 8'h00);
    send_head(4'b0100, a);
    if (!h) begin finish_quiet("R5"); return; end
    sync_phase(lat);
    step(1'b1, 4'hF);
    chk(lad_oe && lad_out == e[3:0], "R8", "read low nibble", lad_out, e[3:0]);
    step(1'b1, 4'hF);
    chk(lad_oe && lad_out == e[7:4], "R8", "read high nibble", lad_out, e[7:4]);
    step(1'b1, 4'hF);
    chk(lad_oe && lad_out == 4'hF, "R6", "target tar", lad_out, 15);
    step(1'b1, 4'hF);
    chk(!lad_oe, "R6", "released after tar", lad_oe, 0);
  endtask

  task automatic do_write(input logic [31:0] a, input logic [7:0] d, input int lat);
    bit h = hits(a);
    resp_lat = lat;
    if (h) push(1'b1, a, d);
    send_head(4'b0111, a);
    if (!h) begin finish_quiet("R5"); return; end
    step(1'b1, d[3:0]);
    step(1'b1, d[7:4]);
    sync_phase(lat);
    step(1'b1, 4'hF);
    chk(lad_oe && lad_out == 4'hF, "R6", "write target tar", lad_out, 15);
    step(1'b1, 4'hF);
    chk(!lad_oe, "R9", "write done, released", lad_oe, 0);
  endtask

  // Read until the first wait sync is on the lines.
  task automatic read_to_wait(input logic [31:0] a, input int lat);
    resp_lat = lat;
    push(1'b0, a, 8'h00);
    send_head(4'b0101, a);
    step(1'b1, 4'hF);
    step(1'b1, 4'hF);
    chk(lad_oe && lad_out == 4'h5, "R7", "wait sync shown", lad_out, 5);
  endtask

  // Downstream responder: ready comes resp_lat clocks after the strobe clock.
  initial begin
    int cnt = -1;
    logic [18:0] cap = '0;
    forever begin
      @(posedge clk);
      #1;
      mem_ready = 1'b0;
      if (mem_rd || mem_wr) begin
        cnt = resp_lat;
        cap = mem_addr;
        if (mem_wr) model[mem_addr[7:0]] = mem_wdata;
      end else if (cnt > 0) begin
        cnt--;
      end
      if (cnt == 0) begin
        mem_ready = 1'b1;
        mem_rdata = model[cap[7:0]];
        cnt = -1;
      end
    end
  end

  // Scoreboard monitor: every strobe must match the next expected request.
  initial begin
    req_t it;
    forever begin
      @(posedge clk);
      #1;
      if (mem_rd || mem_wr) begin
        if (exp_q.size() == 0) begin
          chk(0, "R10", "unexpected strobe", int'(mem_addr), 0);
        end else begin
          it = exp_q.pop_front();
          chk(mem_wr == it.wr && mem_rd == !it.wr, "R10", "strobe kind", mem_wr, it.wr);
          chk(mem_addr == it.addr, "R4", "strobe address", mem_addr, it.addr);
          if (it.wr) chk(mem_wdata == it.data, "R9", "write byte", mem_wdata, it.data);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R10 watchdog expired: got timeout expected completion");
    report();
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'((i * 37 + 11) ^ 8'hA5);

    // R1: reset state
    repeat (3) step(1'b1, 4'hF);
    chk(!lad_oe && !mem_rd && !mem_wr, "R1", "reset state", lad_oe, 0);
    @(negedge clk) iface_rst_n = 1'b1;
    idle(4);

    do_read(32'hFFF8_0010, 0);
    do_read(32'hFFF8_0011, 3);
    do_write(32'hFFF8_0020, 8'h5A, 0);
    do_read(32'hFFF8_0020, 2);
    do_write(32'hFFF8_0021, 8'hC3, 4);
    do_read(32'hFFF8_0021, 1);

    // R2: low frame with a non-start nibble opens nothing
    step(1'b0, 4'h5);
    step(1'b1, 4'b0100);
    for (int i = 0; i < 8; i++) step(1'b1, 4'hF);
    finish_quiet("R2");

    // R3: unsupported cycle types are ignored
    send_head(4'b0000, 32'hFFF8_0030);
    finish_quiet("R3");
    send_head(4'b1000, 32'hFFF8_0031);
    finish_quiet("R3");

    // R5: device select against inverted straps
    do_read(32'hFFE8_0040, 0);
    strap_id = 3'b010;
    do_read(32'hFFE8_0041, 1);
    do_read(32'hFFF8_0042, 0);
    do_write(32'hFFF8_0043, 8'h77, 0);
    do_write(32'hFFE8_0044, 8'h96, 2);
    do_read(32'hFFE8_0044, 0);
    strap_id = 3'b000;

    // R11: abort in the address phase
    step(1'b0, 4'h0);
    step(1'b1, 4'b0100);
    for (int i = 0; i < 3; i++) step(1'b1, 4'hF);
    step(1'b0, 4'hF);
    chk(!lad_oe, "R11", "abort in address", lad_oe, 0);
    idle(12);

    // R11: abort during the wait sync releases the lines on the next edge
    read_to_wait(32'hFFF8_0050, 20);
    step(1'b0, 4'hF);
    chk(!lad_oe, "R11", "abort in sync", lad_oe, 0);
    idle(25);

    // R1: processor reset alone during the wait sync
    read_to_wait(32'hFFF8_0051, 20);
    @(negedge clk) cpu_rst_n = 1'b0;
    step(1'b1, 4'hF);
    chk(!lad_oe && !mem_rd && !mem_wr, "R1", "cpu reset mid cycle", lad_oe, 0);
    @(negedge clk) cpu_rst_n = 1'b1;
    idle(25);

    // R11: abort with a start nibble opens a new cycle at once
    read_to_wait(32'hFFF8_0052, 4);
    do_read(32'hFFF8_0053, 2);

    // R12: abort after write data still delivers the write
    resp_lat = 0;
    push(1'b1, 32'hFFF8_0060, 8'hE1);
    send_head(4'b0110, 32'hFFF8_0060);
    step(1'b1, 4'h1);
    step(1'b1, 4'hE);
    step(1'b0, 4'hF);
    chk(!lad_oe, "R12", "bus released on late abort", lad_oe, 0);
    idle(6);
    do_read(32'hFFF8_0060, 0);

    idle(4);
    chk(exp_q.size() == 0, "R12", "all expected strobes seen", exp_q.size(), 0);
    report();
  end

endmodule